// File: doc/BRIEF.md
# Transmit Frame Assembler

This block turns a series of 32-bit host writes into one outgoing Ethernet frame and sends it out as a byte stream with a ready/valid handshake (AXI4-Stream style). The first write of a frame is a length word. Its low half gives the payload length, which does not count the 14-byte header. Its high half already holds the first two frame bytes. Every later write appends four bytes, lowest byte first. The block decides how many bytes it must collect. That count depends on whether the host also supplies a 4-byte check sequence, which is the case when CRC insertion is off.

The frame bytes are stored in an on-block byte buffer. Once the frame is complete, that buffer is streamed out. Short frames may be extended with zero bytes up to the 60-byte minimum. Two sticky interrupt flags report the results. One says a frame has fully left the block. The other says an oversized length was rejected. Acknowledging the error flag also puts the assembler back into the state where it waits for a length word. Host writes are held off with `wr_ready` while a frame is being streamed.

Top module: `txf_assembler`

## Requirements
- R1: After reset `wr_ready` is 1, `m_tvalid` is 0, and both `irq_tx_empty` and `irq_tx_err` are 0.
- R2: The first accepted write while idle is the length word. Bits 15:0 hold the payload length L. Bits 23:16 become frame byte 0 and bits 31:24 become frame byte 1.
- R3: Each following write supplies the next four frame bytes: bits 7:0 first, then 15:8, 23:16 and 31:24.
- R4: A length word with L > 2032 sets `irq_tx_err` in the next cycle and produces no frame. L = 2032 is accepted.
- R5: While the error flag is set, data writes are accepted and discarded and nothing is streamed. A pulse on `ack_err` clears the flag, and the next write is taken as a new length word.
- R6: Bytes are collected until their count reaches L+14, plus 4 more when `crc_en` was 0. The frame is emitted starting the cycle after the completing write. It is L+14 bytes long, and any collected bytes beyond that are dropped.
- R7: If padding was enabled and L+14 < 60, the frame is 60 bytes long, and bytes L+14 through 59 are zero.
- R8: With padding disabled, or with L+14 >= 60, the emitted length is exactly L+14.
- R9: `m_tdata` and `m_tlast` stay stable while `m_tvalid` is high and `m_tready` is low. `m_tlast` is high only on the final byte.
- R10: `wr_ready` is low for the whole time a frame is being streamed.
- R11: `irq_tx_empty` is set when the final byte is accepted. It stays set until `ack_empty` is pulsed.
- R12: An `ack_err` pulse while bytes are still being collected discards the partial frame, and the next write is a length word.
- R13: `crc_en` and `pad_en` are sampled with the length word. Changing them later has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Host data write request |
| wr_data | input | 32 | Host data word |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| crc_en | input | 1 | CRC insertion on: the host sends no check sequence |
| pad_en | input | 1 | Pad short frames to 60 bytes |
| ack_err | input | 1 | Clear the error flag and re-arm the assembler |
| ack_empty | input | 1 | Clear the transmit-done flag |
| m_tready | input | 1 | Downstream ready |
| m_tvalid | output | 1 | Frame byte valid |
| m_tdata | output | 8 | Frame byte |
| m_tlast | output | 1 | Final byte of the frame |
| irq_tx_empty | output | 1 | Sticky: a frame has fully left |
| irq_tx_err | output | 1 | Sticky: an oversized length was rejected |

## Verification
All inputs are driven on the falling edge, and all outputs are sampled on falling edges. A write is therefore accepted on the rising edge that lies between two samples. The error flag and the drop of `wr_ready` together with the rise of `m_tvalid` appear at the first falling edge after the accepting write, and the bench checks them there. Stream bytes are recorded at each falling edge where valid and ready are both high, which matches the handshake at the following rising edge. The done flag is due one edge after the final handshake, and clearing either flag takes one edge after its acknowledge pulse, so each of these is checked at the next falling edge.

// File: rtl/txf_pkg.sv
package txf_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int CNT_W      = 16;
    localparam int HDR_BYTES  = 14;
    localparam int FCS_BYTES  = 4;
    localparam int MIN_FRAME  = 60;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_SEND = 2'd2,
        ST_ERR  = 2'd3
    } asm_state_e;

    typedef struct packed {
        logic             ok;
        logic             pad;
        logic [CNT_W-1:0] data_len;
        logic [CNT_W-1:0] total;
    } frame_plan_t;

    function automatic logic [CNT_W-1:0] wire_len(input logic [CNT_W-1:0] data_len,
                                                  input logic             pad);
        if (pad && (data_len < CNT_W'(MIN_FRAME)))
            return CNT_W'(MIN_FRAME);
        return data_len;
    endfunction

endpackage

// File: rtl/txf_len_decode.sv
module txf_len_decode
    import txf_pkg::*;
#(
    parameter int MAX_LEN = 2032
) (
    input  logic [15:0] len_field,
    input  logic        crc_en,
    input  logic        pad_en,
    output frame_plan_t plan
);
    logic [CNT_W-1:0] body;

    always_comb begin
        body          = CNT_W'(len_field) + CNT_W'(HDR_BYTES);
        plan.ok       = (len_field <= 16'(MAX_LEN));
        plan.pad      = pad_en;
        plan.data_len = body;
        plan.total    = crc_en ? body : body + CNT_W'(FCS_BYTES);
    end
endmodule

// File: rtl/txf_byte_store.sv
module txf_byte_store
    import txf_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int LANES = WORD_BYTES,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic [LANES-1:0]   lane_en,
    input  logic [CNT_W-1:0]   base,
    input  logic [LANES*8-1:0] wbytes,
    input  logic [AW-1:0]      rd_addr,
    output logic [7:0]         rd_byte
);
    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] lane_addr [LANES];
    logic [LANES-1:0] lane_go;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_addr[g] = base + CNT_W'(g);
        assign lane_go[g]   = lane_en[g] && (lane_addr[g] < CNT_W'(DEPTH));
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < LANES; j++) begin
            if (lane_go[j])
                mem[lane_addr[j][AW-1:0]] <= wbytes[j*8 +: 8];
        end
    end

    assign rd_byte = mem[rd_addr];
endmodule

// File: rtl/txf_streamer.sv
module txf_streamer
    import txf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [CNT_W-1:0] data_len,
    input  logic [CNT_W-1:0] out_len,
    input  logic [7:0]       rd_byte,
    output logic [AW-1:0]    rd_addr,
    input  logic             m_tready,
    output logic             m_tvalid,
    output logic [7:0]       m_tdata,
    output logic             m_tlast,
    output logic             done
);
    logic [CNT_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || !active)
            idx <= '0;
        else if (m_tready)
            idx <= idx + CNT_W'(1);
    end

    assign rd_addr  = idx[AW-1:0];
    assign m_tvalid = active;
    assign m_tdata  = (idx < data_len) ? rd_byte : 8'h00;
    assign m_tlast  = active && (idx == out_len - CNT_W'(1));
    assign done     = m_tvalid && m_tready && m_tlast;
endmodule

// File: rtl/txf_assembler.sv
module txf_assembler
    import txf_pkg::*;
#(
    parameter int MAX_LEN   = 2032,
    parameter int BUF_BYTES = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              crc_en,
    input  logic              pad_en,
    input  logic              ack_err,
    input  logic              ack_empty,
    input  logic              m_tready,
    output logic              m_tvalid,
    output logic [7:0]        m_tdata,
    output logic              m_tlast,
    output logic              irq_tx_empty,
    output logic              irq_tx_err
);
    localparam int AW = $clog2(BUF_BYTES);

    asm_state_e        state;
    frame_plan_t       plan_new;
    frame_plan_t       plan_q;
    logic [CNT_W-1:0]  rcv_q;
    logic [CNT_W-1:0]  rcv_next;
    logic              wr_fire;
    logic              send_done;
    logic [WORD_BYTES-1:0] lane_en;
    logic [CNT_W-1:0]  wbase;
    logic [WORD_W-1:0] wbytes;
    logic [AW-1:0]     rd_addr;
    logic [7:0]        rd_byte;

    assign wr_ready = (state != ST_SEND);
    assign wr_fire  = wr_valid && wr_ready;
    assign rcv_next = rcv_q + CNT_W'(WORD_BYTES);

    txf_len_decode #(.MAX_LEN(MAX_LEN)) u_dec (
        .len_field (wr_data[15:0]),
        .crc_en    (crc_en),
        .pad_en    (pad_en),
        .plan      (plan_new)
    );

    always_comb begin
        lane_en = '0;
        wbase   = rcv_q;
        wbytes  = wr_data;
        if (wr_fire && state == ST_IDLE && plan_new.ok) begin
            lane_en = WORD_BYTES'(2'b11);
            wbase   = '0;
            wbytes  = {16'h0000, wr_data[31:16]};
        end else if (wr_fire && state == ST_FILL && !ack_err) begin
            lane_en = '1;
        end
    end

    txf_byte_store #(.DEPTH(BUF_BYTES)) u_store (
        .clk     (clk),
        .lane_en (lane_en),
        .base    (wbase),
        .wbytes  (wbytes),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    txf_streamer #(.DEPTH(BUF_BYTES)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .active   (state == ST_SEND),
        .data_len (plan_q.data_len),
        .out_len  (wire_len(plan_q.data_len, plan_q.pad)),
        .rd_byte  (rd_byte),
        .rd_addr  (rd_addr),
        .m_tready (m_tready),
        .m_tvalid (m_tvalid),
        .m_tdata  (m_tdata),
        .m_tlast  (m_tlast),
        .done     (send_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            plan_q <= '0;
            rcv_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_fire) begin
                        if (plan_new.ok) begin
                            plan_q <= plan_new;
                            rcv_q  <= CNT_W'(2);
                            state  <= ST_FILL;
                        end else begin
                            state  <= ST_ERR;
                        end
                    end
                end
                ST_FILL: begin
                    if (ack_err) begin
                        state <= ST_IDLE;
                    end else if (wr_fire) begin
                        rcv_q <= rcv_next;
                        if (rcv_next >= plan_q.total)
                            state <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (send_done)
                        state <= ST_IDLE;
                end
                ST_ERR: begin
                    if (ack_err)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_tx_err   <= 1'b0;
            irq_tx_empty <= 1'b0;
        end else begin
            if (state == ST_IDLE && wr_fire && !plan_new.ok)
                irq_tx_err <= 1'b1;
            else if (ack_err)
                irq_tx_err <= 1'b0;

            if (send_done)
                irq_tx_empty <= 1'b1;
            else if (ack_empty)
                irq_tx_empty <= 1'b0;
        end
    end
endmodule

// File: rtl/txf_assembler_chk.sv
module txf_assembler_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_ready,
    input logic       ack_err,
    input logic       ack_empty,
    input logic       m_tready,
    input logic       m_tvalid,
    input logic [7:0] m_tdata,
    input logic       m_tlast,
    input logic       irq_tx_empty,
    input logic       irq_tx_err
);
    // R10
    assert_stall_while_send_R10: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> !wr_ready);

    // R9
    assert_hold_on_backpressure_R9: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R5
    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_tx_err && !ack_err) |=> irq_tx_err);

    // R4
    assert_err_no_stream_R4: assert property (@(posedge clk) disable iff (rst)
        irq_tx_err |-> !m_tvalid);

    // R11
    assert_empty_after_last_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_tx_empty) |-> $past(m_tvalid && m_tready && m_tlast));

    // R11
    assert_empty_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_tx_empty && !ack_empty) |=> irq_tx_empty);
endmodule

bind txf_assembler txf_assembler_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_ready     (wr_ready),
    .ack_err      (ack_err),
    .ack_empty    (ack_empty),
    .m_tready     (m_tready),
    .m_tvalid     (m_tvalid),
    .m_tdata      (m_tdata),
    .m_tlast      (m_tlast),
    .irq_tx_empty (irq_tx_empty),
    .irq_tx_err   (irq_tx_err)
);

// File: tb/txf_assembler_tb.sv
module txf_assembler_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        crc_en = 1'b0;
    logic        pad_en = 1'b0;
    logic        ack_err = 1'b0;
    logic        ack_empty = 1'b0;
    logic        m_tready = 1'b1;
    logic        m_tvalid;
    logic [7:0]  m_tdata;
    logic        m_tlast;
    logic        irq_tx_empty;
    logic        irq_tx_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] cap[$];
    int last_pos = -1;
    int last_cnt = 0;

    always #5 clk = ~clk;

    txf_assembler u_dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .crc_en(crc_en), .pad_en(pad_en),
        .ack_err(ack_err), .ack_empty(ack_empty), .m_tready(m_tready),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .irq_tx_empty(irq_tx_empty), .irq_tx_err(irq_tx_err)
    );

    // Backpressure: changed after each rising edge, stable at falling edges
    initial begin
        int n = 0;
        forever begin
            @(posedge clk);
            #2;
            n++;
            m_tready = ((n % 3) != 2);
        end
    end

    always @(negedge clk) begin
        if (!rst && m_tvalid && m_tready) begin
            cap.push_back(m_tdata);
            if (m_tlast) begin
                last_pos = cap.size() - 1;
                last_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] fb(input int len, input int i);
        return 8'((i * 13 + len * 5 + 1) & 255);
    endfunction

    task automatic put_word(input logic [31:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_ack(input bit e, input bit m);
        @(negedge clk);
        ack_err = e;
        ack_empty = m;
        @(negedge clk);
        ack_err = 1'b0;
        ack_empty = 1'b0;
    endtask

    task automatic clear_cap();
        cap.delete();
        last_pos = -1;
        last_cnt = 0;
    endtask

    task automatic run_frame(input int len, input bit crc, input bit pad);
        int body  = len + 14;
        int total = body + (crc ? 0 : 4);
        int sent  = 2;
        int exp_len = (pad && body < 60) ? 60 : body;
        int bad = -1;
        logic [31:0] w;
        clear_cap();
        crc_en = crc;
        pad_en = pad;
        put_word({fb(len, 1), fb(len, 0), 16'(len)});
        chk(irq_tx_err == 1'b0, "R2/R4 length accepted", int'(irq_tx_err), 0);
        crc_en = ~crc;   // R13: must not influence this frame
        pad_en = ~pad;
        while (sent < total) begin
            for (int k = 0; k < 4; k++)
                w[k*8 +: 8] = (sent + k < body) ? fb(len, sent + k) : 8'hA5;
            put_word(w);
            sent += 4;
        end
        chk(wr_ready == 1'b0 && m_tvalid == 1'b1, "R6/R10 stream start",
            int'({wr_ready, m_tvalid}), 1);
        for (int t = 0; t < 20000 && !irq_tx_empty; t++) @(negedge clk);
        chk(irq_tx_empty == 1'b1, "R11 done flag", int'(irq_tx_empty), 1);
        chk(cap.size() == exp_len, "R6/R7/R8/R13 length", cap.size(), exp_len);
        for (int i = 0; i < cap.size() && i < exp_len; i++) begin
            logic [7:0] e = (i < body) ? fb(len, i) : 8'h00;
            if (bad < 0 && cap[i] != e) bad = i;
        end
        if (bad >= 0)
            chk(1'b0, "R2/R3/R7 byte content", int'(cap[bad]), int'((bad < body) ? fb(len, bad) : 8'h00));
        else
            chk(1'b1, "R2/R3/R7 byte content", 0, 0);
        chk(last_cnt == 1 && last_pos == exp_len - 1, "R9 tlast position", last_pos, exp_len - 1);
        pulse_ack(1'b0, 1'b1);
        chk(irq_tx_empty == 1'b0, "R11 ack clears done", int'(irq_tx_empty), 0);
        crc_en = crc;
        pad_en = pad;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(wr_ready == 1'b1 && m_tvalid == 1'b0, "R1 reset handshake",
            int'({wr_ready, m_tvalid}), 2);
        chk(irq_tx_empty == 1'b0 && irq_tx_err == 1'b0, "R1 reset flags",
            int'({irq_tx_empty, irq_tx_err}), 0);

        // Sweep across the padding boundary with all option combinations
        for (int len = 0; len < 48; len++)
            for (int c = 0; c < 2; c++)
                for (int p = 0; p < 2; p++)
                    run_frame(len, c[0], p[0]);
        run_frame(120, 1'b0, 1'b1);   // R8 long frame, pad enabled

        // R4: oversize length is rejected
        clear_cap();
        put_word({16'h1234, 16'd2033});
        chk(irq_tx_err == 1'b1, "R4 oversize sets error", int'(irq_tx_err), 1);
        chk(wr_ready == 1'b1, "R5 writes still accepted", int'(wr_ready), 1);
        for (int k = 0; k < 4; k++) put_word(32'hDEAD_0000 + 32'(k));
        repeat (6) @(negedge clk);
        chk(cap.size() == 0 && m_tvalid == 1'b0, "R5 writes discarded", cap.size(), 0);
        chk(irq_tx_err == 1'b1, "R5 error held", int'(irq_tx_err), 1);
        pulse_ack(1'b1, 1'b0);
        chk(irq_tx_err == 1'b0, "R5 ack clears error", int'(irq_tx_err), 0);
        run_frame(5, 1'b1, 1'b0);     // R5 next write is a length word

        put_word({16'h0000, 16'hFFFF});
        chk(irq_tx_err == 1'b1, "R4 max field rejected", int'(irq_tx_err), 1);
        pulse_ack(1'b1, 1'b0);

        run_frame(2032, 1'b1, 1'b0);  // R4 upper bound accepted

        // R12: abort a partial frame
        clear_cap();
        crc_en = 1'b1;
        put_word({16'h0102, 16'd40});
        for (int k = 0; k < 3; k++) put_word(32'h5555_5555);
        pulse_ack(1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk(cap.size() == 0 && m_tvalid == 1'b0, "R12 partial frame dropped", cap.size(), 0);
        run_frame(3, 1'b1, 1'b1);     // R12 re-armed

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule